// File: doc/BRIEF.md
# USB Bus Idle-State and Speed Detector

This block watches the two USB data lines between packets. It times each single-ended-zero (SE0) interval in clock cycles. When the interval ends it decides whether the bus saw a reset, a low-speed keep-alive, or only a short SE0 such as the tail of a packet. In automatic mode it reads the idle level that follows to choose the signalling speed that the packet receiver should use.

The packet receiver consumes the speed code. When the receiver recognises a low-speed preamble, it raises `hub_pre`. The detector then enters the low-speed-through-hub mode, which uses the low-speed rate with full-speed line polarity. The next SE0 of two or more cycles ends that mode. Software or strapping sets `cfg_mode`. A fixed full or low setting pins the speed, and the block then only reports reset and keep-alive events.

Top module: `usb_idle_speed_sense`

## Requirements
- R1: The line pair `{dp,dm}` is read as 2'b00 SE0, 2'b10 full-speed J, 2'b01 low-speed J and 2'b11 SE1. In automatic mode (`cfg_mode` 0 or 3), an SE0 of two or more cycles that ends on full-speed J sets `speed` to 0 (full). One that ends on low-speed J sets `speed` to 1 (low). Both take effect one cycle after the first non-SE0 sample.
- R2: While reset is held, `speed` is 0 and both pulses are 0. In automatic mode, the first non-SE0 level after reset release picks the speed as in R1.
- R3: An SE0 longer than RST_CYC cycles raises `bus_reset` for one cycle, one cycle after the first non-SE0 sample. RST_CYC is 2.5 µs rounded up to whole clock cycles.
- R4: An SE0 longer than KA_CYC cycles but not longer than RST_CYC cycles raises `keep_alive` for one cycle at the same point, but only when `speed` is 1 (low). KA_CYC is 1.2 µs rounded up to whole clock cycles.
- R5: After a bus reset, `speed` returns to the configured setting. In automatic mode that setting is the level the line idles at.
- R6: An SE0 of exactly one cycle gives no pulse and leaves `speed` unchanged.
- R7: With `cfg_mode` 1 (full) or 2 (low), `speed` follows the configuration within one cycle and is never changed by the line level.
- R8: A `hub_pre` pulse while `speed` is 0 and the line is not SE0 sets `speed` to 2 (low via hub). The end of the next SE0 of two or more cycles leaves that mode: in automatic mode through the line level, where an SE1 idle gives full speed; in fixed modes through the configured setting.
- R9: An SE0 of at least two cycles but no more than KA_CYC cycles gives no pulse.
- R10: `bus_reset` and `keep_alive` are never high together, and each is high for only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dp | input | 1 | Sampled D+ line |
| dm | input | 1 | Sampled D- line |
| cfg_mode | input | 2 | 0/3 automatic, 1 fixed full, 2 fixed low |
| hub_pre | input | 1 | Preamble seen by the packet receiver (one-cycle pulse) |
| speed | output | 2 | 0 full, 1 low, 2 low via hub |
| bus_reset | output | 1 | One-cycle bus reset pulse |
| keep_alive | output | 1 | One-cycle low-speed keep-alive pulse |

## Verification
The bench builds the block with CLK_HZ at 12 MHz. That gives a reset limit of 30 cycles and a keep-alive limit of 15 cycles. SE0 lengths of 1, 2, 15, 16, 30, 31 and beyond therefore cost only tens of cycles each. With these limits a few hundred random SE0/idle events, mixed with configuration changes and preamble pulses, cover every limit crossing in every speed mode.

// File: rtl/usb_idle_pkg.sv
package usb_idle_pkg;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_LSJ = 2'b01,
        LN_FSJ = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        SPD_FULL = 2'd0,
        SPD_LOW  = 2'd1,
        SPD_HUB  = 2'd2
    } speed_e;

    localparam logic [1:0] CFG_AUTO = 2'd0;
    localparam logic [1:0] CFG_FULL = 2'd1;
    localparam logic [1:0] CFG_LOW  = 2'd2;

    // Nanoseconds to clock cycles, rounded up.
    function automatic int ns_to_cycles(longint hz, longint ns);
        return int'((hz / 1000 * ns + 999_999) / 1_000_000);
    endfunction

endpackage

// File: rtl/usb_line_class.sv
module usb_line_class
    import usb_idle_pkg::*;
(
    input  logic  dp,
    input  logic  dm,
    output line_e level
);
    always_comb begin
        unique case ({dp, dm})
            2'b00:   level = LN_SE0;
            2'b10:   level = LN_FSJ;
            2'b01:   level = LN_LSJ;
            default: level = LN_SE1;
        endcase
    end
endmodule

// File: rtl/usb_se0_timer.sv
module usb_se0_timer #(
    parameter int KA_CYC  = 58,
    parameter int RST_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_se0,
    output logic se0_done,
    output logic len_multi,
    output logic len_ka,
    output logic len_rst
);
    localparam int CNT_MAX = RST_CYC + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!in_se0)
            cnt_d = '0;
        else if (cnt_q != CW'(CNT_MAX))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign se0_done  = !in_se0 && (cnt_q != '0);
    assign len_multi = cnt_q >= CW'(2);
    assign len_ka    = cnt_q >  CW'(KA_CYC);
    assign len_rst   = cnt_q >  CW'(RST_CYC);

    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CNT_MAX));
    assert_done_after_se0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        se0_done |-> $past(in_se0));
endmodule

// File: rtl/usb_speed_ctl.sv
module usb_speed_ctl
    import usb_idle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_e      level,
    input  logic [1:0] cfg_mode,
    input  logic       hub_pre,
    input  logic       se0_done,
    input  logic       len_multi,
    input  logic       len_ka,
    input  logic       len_rst,
    output speed_e     speed,
    output logic       rst_pulse,
    output logic       ka_pulse
);
    typedef struct packed {
        speed_e speed;
        logic   init;
        logic   rst_p;
        logic   ka_p;
    } ctl_s;

    ctl_s st_d, st_q;
    logic   is_auto;
    speed_e cfg_speed;
    speed_e line_speed;

    always_comb begin
        is_auto   = (cfg_mode == CFG_AUTO) || (cfg_mode == 2'd3);
        cfg_speed = (cfg_mode == CFG_LOW) ? SPD_LOW : SPD_FULL;
        unique case (level)
            LN_FSJ:  line_speed = SPD_FULL;
            LN_LSJ:  line_speed = SPD_LOW;
            default: line_speed = (st_q.speed == SPD_HUB) ? SPD_FULL : st_q.speed;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.rst_p = se0_done && len_rst;
        st_d.ka_p  = se0_done && len_ka && !len_rst && (st_q.speed == SPD_LOW);
        if (level != LN_SE0)
            st_d.init = 1'b0;

        if (hub_pre && level != LN_SE0 && st_q.speed == SPD_FULL)
            st_d.speed = SPD_HUB;
        else if (se0_done && len_multi)
            st_d.speed = is_auto ? line_speed : cfg_speed;
        else if (st_q.init && is_auto && level != LN_SE0)
            st_d.speed = line_speed;
        else if (!is_auto && st_q.speed != SPD_HUB)
            st_d.speed = cfg_speed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{speed: SPD_FULL, init: 1'b1, rst_p: 1'b0, ka_p: 1'b0};
        else        st_q <= st_d;
    end

    assign speed     = st_q.speed;
    assign rst_pulse = st_q.rst_p;
    assign ka_pulse  = st_q.ka_p;

    assert_ka_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ka_pulse |-> $past(st_q.speed) == SPD_LOW);
    assert_fixed_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == CFG_FULL && speed != SPD_HUB) |=> (speed == SPD_FULL || speed == SPD_HUB));
    assert_fixed_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == CFG_LOW && speed != SPD_HUB) |=> (speed == SPD_LOW || speed == SPD_HUB));
    assert_hub_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(speed == SPD_HUB) |-> $past(hub_pre));
endmodule

// File: rtl/usb_idle_speed_sense.sv
module usb_idle_speed_sense
    import usb_idle_pkg::*;
#(
    parameter longint CLK_HZ    = 48_000_000,
    parameter int     RESET_NS  = 2500,
    parameter int     KALIVE_NS = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp,
    input  logic       dm,
    input  logic [1:0] cfg_mode,
    input  logic       hub_pre,
    output logic [1:0] speed,
    output logic       bus_reset,
    output logic       keep_alive
);
    localparam int RST_CYC = ns_to_cycles(CLK_HZ, longint'(RESET_NS));
    localparam int KA_CYC  = ns_to_cycles(CLK_HZ, longint'(KALIVE_NS));

    initial begin
        if (KA_CYC < 2 || KA_CYC >= RST_CYC)
            $error("SE0 limits out of order: %0d / %0d", KA_CYC, RST_CYC);
    end

    line_e  level;
    speed_e spd;
    logic   se0_done, len_multi, len_ka, len_rst;

    usb_line_class u_class (
        .dp    (dp),
        .dm    (dm),
        .level (level)
    );

    usb_se0_timer #(.KA_CYC(KA_CYC), .RST_CYC(RST_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_se0    (level == LN_SE0),
        .se0_done  (se0_done),
        .len_multi (len_multi),
        .len_ka    (len_ka),
        .len_rst   (len_rst)
    );

    usb_speed_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .cfg_mode  (cfg_mode),
        .hub_pre   (hub_pre),
        .se0_done  (se0_done),
        .len_multi (len_multi),
        .len_ka    (len_ka),
        .len_rst   (len_rst),
        .speed     (spd),
        .rst_pulse (bus_reset),
        .ka_pulse  (keep_alive)
    );

    assign speed = spd;

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_reset && keep_alive));
    assert_pulse_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset || keep_alive) |-> $past({dp, dm} != 2'b00));
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset || keep_alive) |=> !(bus_reset || keep_alive));
endmodule

// File: tb/test_usb_idle_speed_sense.sv
module test_usb_idle_speed_sense;
    localparam int RST = 30;
    localparam int KA  = 15;
    localparam logic [1:0] SE0 = 2'b00, FSJ = 2'b10, LSJ = 2'b01, SE1 = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp = 1'b0, dm = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic hub_pre = 1'b0;
    logic [1:0] speed;
    logic bus_reset, keep_alive;

    int n_run = 0, n_fail = 0;
    logic [1:0] m_spd;
    logic [1:0] m_cfg;

    always #2 clk = ~clk;

    usb_idle_speed_sense #(.CLK_HZ(12_000_000)) i_usb_idle_speed_sense (
        .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .cfg_mode(cfg_mode),
        .hub_pre(hub_pre), .speed(speed), .bus_reset(bus_reset), .keep_alive(keep_alive)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_auto(input logic [1:0] c);
        return c == 2'd0 || c == 2'd3;
    endfunction

    function automatic logic [1:0] exp_speed(input int len, input logic [1:0] lvl,
                                             input logic [1:0] c, input logic [1:0] s);
        if (len < 2) return s;
        if (c == 2'd1) return 2'd0;
        if (c == 2'd2) return 2'd1;
        if (lvl == FSJ) return 2'd0;
        if (lvl == LSJ) return 2'd1;
        return (s == 2'd2) ? 2'd0 : s;
    endfunction

    task automatic se0_event(input int len, input logic [1:0] lvl, input string req);
        bit e_rst, e_ka;
        logic [1:0] e_spd;
        e_rst = len > RST;
        e_ka  = len > KA && len <= RST && m_spd == 2'd1;
        e_spd = exp_speed(len, lvl, m_cfg, m_spd);
        {dp, dm} = SE0;
        repeat (len) @(negedge clk);
        {dp, dm} = lvl;
        @(negedge clk);
        check(bus_reset == e_rst, {req, " R3 reset pulse"}, bus_reset, e_rst);
        check(keep_alive == e_ka, {req, " R4 keep-alive pulse"}, keep_alive, e_ka);
        check(speed == e_spd, {req, " R1 speed after SE0"}, speed, e_spd);
        @(negedge clk);
        check(!bus_reset && !keep_alive, {req, " R10 single-cycle pulse"},
              {bus_reset, keep_alive}, 0);
        m_spd = e_spd;
    endtask

    task automatic set_cfg(input logic [1:0] c);
        cfg_mode = c;
        m_cfg = c;
        if (!is_auto(c) && m_spd != 2'd2) m_spd = (c == 2'd2) ? 2'd1 : 2'd0;
        repeat (2) @(negedge clk);
        check(speed == m_spd, "R7 speed after config change", speed, m_spd);
    endtask

    task automatic pulse_hub();
        hub_pre = 1'b1;
        @(negedge clk);
        hub_pre = 1'b0;
        if (m_spd == 2'd0) m_spd = 2'd2;
        check(speed == m_spd, "R8 preamble entry", speed, m_spd);
    endtask

    initial begin
        #(4 * 200_000);
        check(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_cfg = 2'd0;
        repeat (3) @(negedge clk);
        check(speed == 2'd0 && !bus_reset && !keep_alive, "R2 reset state", speed, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(speed == 2'd1, "R2 power-up low-speed idle", speed, 1);
        m_spd = 2'd1;

        se0_event(1, FSJ, "R6 glitch");
        se0_event(31, FSJ, "R5 reset to full");
        se0_event(30, FSJ, "R4 no keep-alive at full");
        se0_event(20, LSJ, "R1 switch to low");
        se0_event(16, LSJ, "R4 keep-alive lower edge");
        se0_event(15, LSJ, "R9 at keep-alive limit");
        se0_event(30, LSJ, "R4 keep-alive upper edge");
        se0_event(2, LSJ, "R9 two-cycle SE0");
        se0_event(1, FSJ, "R6 glitch at low");
        se0_event(2, FSJ, "R1 short SE0 to full");
        pulse_hub();
        se0_event(31, FSJ, "R5 reset leaves hub");
        pulse_hub();
        se0_event(5, SE1, "R8 hub exit on SE1");
        set_cfg(2'd2);
        se0_event(3, FSJ, "R7 fixed low ignores line");
        se0_event(20, FSJ, "R4 keep-alive fixed low");
        set_cfg(2'd1);
        pulse_hub();
        se0_event(40, LSJ, "R5 reset in fixed full");
        set_cfg(2'd0);

        for (int i = 0; i < 300; i++) begin
            int len;
            logic [1:0] lvl;
            int r;
            r = $urandom % 20;
            if (r == 0) set_cfg(2'($urandom % 4));
            else if (r == 1) pulse_hub();
            case ($urandom % 8)
                0: len = 1;
                1: len = 2;
                2: len = KA;
                3: len = KA + 1;
                4: len = RST;
                5: len = RST + 1;
                default: len = 2 + int'($urandom % (RST + 10));
            endcase
            case ($urandom % 3)
                0: lvl = FSJ;
                1: lvl = LSJ;
                default: lvl = SE1;
            endcase
            se0_event(len, lvl, "random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule